// File: doc/BRIEF.md
# System Management Interrupt Sequencer

This block steers a simple in-order core into and out of its system management mode. An asynchronous, active-low request line is synchronized, and a falling edge on it latches one request. That request becomes an entry request to the core on the next instruction boundary or repeat-string iteration boundary, provided no locked bus sequence is in flight.

After the core signals that its state-save sequence has started, the block drives an active-low mode indicator low. The indicator stays low until the core reports its final state-restore cycle, and that report counts only after a resume instruction has retired. While the mode is active, a single further falling edge is held in a one-bit pending slot, and further edges are lost. The held request stays parked until the mode has been left, and is then handled like any fresh request.

Top module: `smi_seq`

## Requirements
- R1: `req_ni` passes through a two-stage synchronizer. A falling edge sets `pend_o` high on the third rising clock edge after the low level is first sampled. Holding the line low creates no further request.
- R2: A pending request is taken on a clock edge where `insn_bnd_i` or `rep_iter_i` is high. Taking it raises `entry_req_o` and clears `pend_o` after that edge. With neither strobe high, `entry_req_o` stays low.
- R3: While `locked_i` is high, a pending request is not taken even on a boundary strobe. It stays pending until a strobe arrives with `locked_i` low.
- R4: `entry_req_o` stays high until an edge where `save_start_i` is high. After that edge `entry_req_o` is low and `mode_act_no` is low.
- R5: `mode_act_no` stays low until `restore_done_i` is seen after `rsm_i`, and goes high on the edge that samples `restore_done_i`. A `restore_done_i` seen before `rsm_i` has no effect.
- R6: A falling edge while requesting or in the mode sets `pend_o`. Further edges leave exactly one request. Boundary strobes during the mode never raise `entry_req_o`.
- R7: A request held during the mode is serviced only after exit: the first boundary strobe in normal mode raises `entry_req_o`.
- R8: After `rst_ni` is released, `entry_req_o` and `pend_o` are low and `mode_act_no` is high.
- R9: `rsm_i`, `save_start_i` and `restore_done_i` have no effect while the block is in normal mode with no entry request outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_ni | input | 1 | Asynchronous active-low management request |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| rep_iter_i | input | 1 | Repeat-string iteration boundary strobe |
| locked_i | input | 1 | Locked bus sequence in progress |
| rsm_i | input | 1 | Resume instruction completed |
| save_start_i | input | 1 | State-save sequence begins |
| restore_done_i | input | 1 | Last state-restore cycle done |
| entry_req_o | output | 1 | Entry request to the core |
| mode_act_no | output | 1 | Management mode active, low true |
| pend_o | output | 1 | One request latched and waiting |

## Verification
All outputs are registered, so each result is due a fixed number of cycles after its stimulus. `pend_o` follows a falling request three clock edges after the first low sample. `entry_req_o` and `mode_act_no` follow a strobe one edge after the strobe is sampled. The bench drives inputs just after a falling clock edge and reads outputs at the next falling edge, so every check lands exactly on the cycle its requirement names. One sweep walks all eight combinations of lock and the two boundary strobes against a pending request, and the expected entry is computed arithmetically.

// File: rtl/smi_pkg.sv
package smi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_SMM  = 2'd2,
    ST_EXIT = 2'd3
  } smi_state_e;
endpackage

// File: rtl/smi_sync.sv
module smi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/smi_edge.sv
module smi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;

  assign fall_o = prev_q & ~lvl_i;

  // R1
  single_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/smi_pend.sv
module smi_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  // a new edge wins over a take in the same cycle: it is a nested request
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (take_i) pend_q <= 1'b0;

  assign pend_o = pend_q;

  // R1
  pend_from_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(set_i));
  // R2
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_o) |-> $past(take_i));
endmodule

// File: rtl/smi_fsm.sv
module smi_fsm
  import smi_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic insn_bnd_i,
  input  logic rep_iter_i,
  input  logic locked_i,
  input  logic rsm_i,
  input  logic save_start_i,
  input  logic restore_done_i,
  output logic take_o,
  output logic entry_req_o,
  output logic mode_act_no
);
  smi_state_e st_q, st_d;

  assign take_o = (st_q == ST_IDLE) && pend_i && (insn_bnd_i || rep_iter_i) && !locked_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (take_o)         st_d = ST_REQ;
      ST_REQ:  if (save_start_i)   st_d = ST_SMM;
      ST_SMM:  if (rsm_i)          st_d = ST_EXIT;
      ST_EXIT: if (restore_done_i) st_d = ST_IDLE;
      default:                     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;

  assign entry_req_o = (st_q == ST_REQ);
  assign mode_act_no = !((st_q == ST_SMM) || (st_q == ST_EXIT));

  // R3
  no_take_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && locked_i) |=> !entry_req_o);
  // R6
  no_entry_in_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(entry_req_o && !mode_act_no));
  // R4
  mode_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mode_act_no) |-> $past(entry_req_o && save_start_i));
  // R5
  mode_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_act_no) |-> $past(restore_done_i && st_q == ST_EXIT));
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_req_o && !save_start_i) |=> entry_req_o);
endmodule

// File: rtl/smi_seq.sv
module smi_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic insn_bnd_i,
  input  logic rep_iter_i,
  input  logic locked_i,
  input  logic rsm_i,
  input  logic save_start_i,
  input  logic restore_done_i,
  output logic entry_req_o,
  output logic mode_act_no,
  output logic pend_o
);
  logic req_sync, req_fall, take;

  smi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_ni), .q_o(req_sync));

  smi_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(req_sync), .fall_o(req_fall));

  smi_pend u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(req_fall), .take_i(take), .pend_o(pend_o));

  smi_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend_o),
    .insn_bnd_i(insn_bnd_i), .rep_iter_i(rep_iter_i), .locked_i(locked_i),
    .rsm_i(rsm_i), .save_start_i(save_start_i), .restore_done_i(restore_done_i),
    .take_o(take), .entry_req_o(entry_req_o), .mode_act_no(mode_act_no));

  // R2
  entry_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(entry_req_o) |-> $past(pend_o && (insn_bnd_i || rep_iter_i)));
endmodule

// File: tb/sim_smi_seq.sv
module sim_smi_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1, ib = 1'b0, ri = 1'b0, lk = 1'b0, rsm = 1'b0, sv = 1'b0, rd = 1'b0;
  logic ent, mode_n, pend;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  smi_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_n), .insn_bnd_i(ib), .rep_iter_i(ri),
    .locked_i(lk), .rsm_i(rsm), .save_start_i(sv), .restore_done_i(rd),
    .entry_req_o(ent), .mode_act_no(mode_n), .pend_o(pend));

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic fall_req();
    req_n = 1'b0; tick(3);
    req_n = 1'b1; tick(3);
  endtask

  task automatic pulse_sv();  sv = 1'b1;  tick(); sv = 1'b0;  endtask
  task automatic pulse_rsm(); rsm = 1'b1; tick(); rsm = 1'b0; endtask
  task automatic pulse_rd();  rd = 1'b1;  tick(); rd = 1'b0;  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    // R8
    chk("R8 entry", ent, 1'b0);
    chk("R8 mode", mode_n, 1'b1);
    chk("R8 pend", pend, 1'b0);

    // R9: mode handshakes in normal mode do nothing
    pulse_rsm(); pulse_sv(); pulse_rd();
    chk("R9 mode", mode_n, 1'b1);
    chk("R9 entry", ent, 1'b0);

    // R1: latency and level hold
    req_n = 1'b0;
    tick(2);
    chk("R1 pend early", pend, 1'b0);
    tick();
    chk("R1 pend", pend, 1'b1);
    tick(5);
    // R2: no strobe, no entry
    chk("R2 no strobe", ent, 1'b0);
    ib = 1'b1; tick(); ib = 1'b0;
    chk("R2 entry", ent, 1'b1);
    chk("R2 pend cleared", pend, 1'b0);
    tick(4);
    chk("R1 level no retrigger", pend, 1'b0);
    // R4
    chk("R4 hold", ent, 1'b1);
    pulse_sv();
    chk("R4 entry low", ent, 1'b0);
    chk("R4 mode low", mode_n, 1'b0);
    req_n = 1'b1; tick(3);
    // R5: restore before resume ignored
    pulse_rd();
    chk("R5 early restore", mode_n, 1'b0);

    // R6: nested edges during mode
    fall_req();
    chk("R6 pend", pend, 1'b1);
    fall_req();
    ib = 1'b1; ri = 1'b1; tick(); ib = 1'b0; ri = 1'b0;
    chk("R6 no entry in mode", ent, 1'b0);
    pulse_rsm();
    chk("R5 after rsm", mode_n, 1'b0);
    pulse_rd();
    chk("R5 exit", mode_n, 1'b1);
    chk("R7 pend kept", pend, 1'b1);
    tick(2);
    chk("R7 waits for strobe", ent, 1'b0);
    ri = 1'b1; tick(); ri = 1'b0;
    chk("R7 entry", ent, 1'b1);
    chk("R6 single slot", pend, 1'b0);
    pulse_sv(); pulse_rsm(); pulse_rd();
    chk("R6 no second entry", ent, 1'b0);

    // R3 and R2 sweep over lock and both strobes
    for (int c = 0; c < 8; c++) begin
      logic e;
      fall_req();
      chk("R1 pend sweep", pend, 1'b1);
      lk = c[2]; ib = c[1]; ri = c[0];
      e = (c[1] | c[0]) & ~c[2];
      tick();
      lk = 1'b0; ib = 1'b0; ri = 1'b0;
      chk(c[2] ? "R3 lock sweep" : "R2 strobe sweep", ent, e);
      chk("R3 pend sweep", pend, ~e);
      if (e) begin
        pulse_sv(); pulse_rsm(); pulse_rd();
      end else if (c[2] && (c[1] | c[0])) begin
        ib = 1'b1; tick(); ib = 1'b0;
        chk("R3 after unlock", ent, 1'b1);
        pulse_sv(); pulse_rsm(); pulse_rd();
      end
    end
    chk("R8 idle end", mode_n, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule